// File: doc/BRIEF.md
# Serial Start-of-Frame Byte Framer with Address Reject

This block watches a recovered serial receive stream: a data bit, the bit clock that came with it, and a receive-active flag. The bit clock toggles only while a frame arrives. All three inputs are synchronized into the system clock domain. A bit is taken on each rising edge of the synchronized bit clock. The block runs the whole time on the free-running system clock, so it never needs the bit clock between frames.

While hunting, the block watches the alternating preamble without storing it. It waits for the closing pair of ones of the start-of-frame delimiter. It then pulses a frame marker and packs the following bits into bytes, least significant bit first. The marker pulses again at each byte boundary, and the completed byte is presented with a valid pulse.

The first six bytes form the destination address. This address is compared against a small table of four programmable 48-bit entries, each with its own enable bit. If no enabled entry matches, an active-low reject output is held low for a programmable number of system clocks. The programmed length is chosen to cover the minimum reject width the attached receiver needs.

Top module: `sfd_byte_framer`

## Requirements
- R1: After reset, `rej_n` is high and `sof_mark` and `byte_vld` are low.
- R2: `sof_mark` pulses for one clock when the last eight bits received, in arrival order, are 1,0,1,0,1,0,1,1. No preamble bit and no delimiter bit produces a `byte_vld` pulse.
- R3: No delimiter is detected in either of these cases: a pattern broken before the final ones, such as 1,0,1,0,0,0,1,1; or a pair of ones arriving within the first eight bits after `rx_active` rises.
- R4: After the delimiter, every eight bits produce one `byte_vld` pulse. The first bit received is placed in `byte_out[0]`. `sof_mark` also pulses with each `byte_vld`.
- R5: Bytes 0 to 5 after the delimiter form the destination address, with byte k in bits [8k+7:8k]. Table entry i occupies `tbl_addr[48i+47:48i]` and takes part in the compare only when `tbl_en[i]` is 1.
- R6: When the sixth byte matches no enabled entry, `rej_n` goes low exactly once for that frame. It stays low for exactly `rej_len` clocks, and a `rej_len` of 0 acts as 1.
- R7: A match on any enabled entry gives no reject. A match only on a disabled entry is a miss.
- R8: A fall of `rx_active` re-arms the delimiter search and clears the address. A frame ending before its sixth byte gives no reject, and the next frame is framed normally.
- R9: A reject pulse that has started runs to its full width, even if `rx_active` falls and the bit clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_active | input | 1 | High while a frame is being received |
| rx_bclk | input | 1 | Recovered bit clock; a bit is taken on its rising edge |
| rx_data | input | 1 | Recovered serial data |
| tbl_addr | input | NUM_ENT*48 | Flattened address table, entry i at [48i+47:48i] |
| tbl_en | input | NUM_ENT | Per-entry enable |
| rej_len | input | CNT_W | Reject pulse length in system clocks (0 acts as 1) |
| sof_mark | output | 1 | Pulse at delimiter detection and at each byte boundary |
| byte_out | output | 8 | Last completed byte |
| byte_vld | output | 1 | One-clock pulse when byte_out is new |
| rej_n | output | 1 | Active-low reject pulse |

## Verification
A table of frames is run against a fixed address table. It holds matches on two different enabled entries, an address close to an entry that differs in one bit, an address unrelated to any entry, and an exact match on the disabled entry. These cases separate a correct full-width compare from one that ignores a byte, ignores the enables, or stops at the first entry. Directed frames then cover the following:
- a broken delimiter and early ones, which separate a full eight-bit delimiter check from a simple two-ones detector;
- a frame cut short after three bytes, which shows that the reject decision waits for the sixth byte;
- a miss followed at once by the end of the frame, which shows that the pulse width does not depend on the bit clock;
- a zero length, which confirms the one-clock minimum.

// File: rtl/sfdf_pkg.sv
package sfdf_pkg;
    localparam int BYTE_W = 8;
    // delimiter in arrival order, oldest bit in the MSB
    localparam logic [BYTE_W-1:0] SFD_PATTERN = 8'b1010_1011;

    typedef enum logic {ST_HUNT, ST_DATA} hunt_st_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    // shift register for LSB-first deserializing
    function automatic logic [BYTE_W-1:0] push_lsb_first(logic [BYTE_W-1:0] cur, logic b);
        return {b, cur[BYTE_W-1:1]};
    endfunction

    // history register for delimiter search
    function automatic logic [BYTE_W-1:0] push_history(logic [BYTE_W-1:0] cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction
endpackage

// File: rtl/sfdf_sync_edge.sv
module sfdf_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_in,
    input  logic bclk_in,
    input  logic data_in,
    output logic act,
    output logic bit_evt,
    output logic bit_val
);
    // lane 2 = active, lane 1 = bit clock, lane 0 = data
    logic [2:0] pipe [STAGES];
    logic       bclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            bclk_d <= 1'b0;
        end else begin
            pipe[0] <= {act_in, bclk_in, data_in};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            bclk_d <= pipe[STAGES-1][1];
        end
    end

    assign act     = pipe[STAGES-1][2];
    assign bit_val = pipe[STAGES-1][0];
    assign bit_evt = act && pipe[STAGES-1][1] && !bclk_d;
endmodule

// File: rtl/sfdf_hunt.sv
module sfdf_hunt
    import sfdf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     act,
    input  logic     bit_evt,
    input  logic     bit_val,
    output logic     mark,
    output rx_byte_t rx_byte
);
    hunt_st_t          state;
    logic [BYTE_W-1:0] hist;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bcnt;
    logic [BYTE_W-1:0] hist_n;
    logic [BYTE_W-1:0] sh_n;

    assign hist_n = push_history(hist, bit_val);
    assign sh_n   = push_lsb_first(shreg, bit_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HUNT;
            hist         <= '0;
            shreg        <= '0;
            bcnt         <= '0;
            mark         <= 1'b0;
            rx_byte.vld  <= 1'b0;
            rx_byte.data <= '0;
        end else begin
            mark        <= 1'b0;
            rx_byte.vld <= 1'b0;
            if (!act) begin
                state <= ST_HUNT;
                hist  <= '0;
                bcnt  <= '0;
            end else if (bit_evt) begin
                if (state == ST_HUNT) begin
                    hist <= hist_n;
                    if (hist_n == SFD_PATTERN) begin
                        state <= ST_DATA;
                        bcnt  <= '0;
                        mark  <= 1'b1;
                    end
                end else begin
                    shreg <= sh_n;
                    bcnt  <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        rx_byte.vld  <= 1'b1;
                        rx_byte.data <= sh_n;
                        mark         <= 1'b1;
                    end
                end
            end
        end
    end

    AST_BYTE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        rx_byte.vld |-> $past(bit_evt)); // R4
    AST_MARK_AT_BYTE: assert property (@(posedge clk) disable iff (rst)
        rx_byte.vld |-> mark); // R4
    AST_IDLE_NO_BYTES: assert property (@(posedge clk) disable iff (rst)
        !act |=> !rx_byte.vld && !mark); // R8
endmodule

// File: rtl/sfdf_addr_match.sv
module sfdf_addr_match
    import sfdf_pkg::*;
#(
    parameter int NUM_ENT    = 4,
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
    localparam int IDX_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      act,
    input  rx_byte_t                  rx_byte,
    input  logic [NUM_ENT*ADDR_W-1:0] tbl_addr,
    input  logic [NUM_ENT-1:0]        tbl_en,
    output logic                      miss
);
    logic [ADDR_W-1:0]  addr_q;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  cand;
    logic [NUM_ENT-1:0] hit;
    logic               last_byte;

    assign cand      = {rx_byte.data, addr_q[ADDR_W-BYTE_W-1:0]};
    assign last_byte = rx_byte.vld && (idx == IDX_W'(ADDR_BYTES - 1));

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        assign hit[i] = tbl_en[i] && (tbl_addr[i*ADDR_W +: ADDR_W] == cand);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            idx    <= '0;
            miss   <= 1'b0;
        end else begin
            miss <= act && last_byte && (hit == '0);
            if (!act) begin
                idx    <= '0;
                addr_q <= '0;
            end else if (rx_byte.vld && idx < IDX_W'(ADDR_BYTES)) begin
                addr_q[idx*BYTE_W +: BYTE_W] <= rx_byte.data;
                idx <= idx + 1'b1;
            end
        end
    end

    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        miss |=> !miss); // R6
    AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (rst)
        (last_byte && hit != '0) |=> !miss); // R7
endmodule

// File: rtl/sfdf_reject.sv
module sfdf_reject #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             rej_n
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= (len == '0) ? CNT_W'(1) : len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign rej_n = (cnt == '0);

    AST_REJ_NEEDS_MISS: assert property (@(posedge clk) disable iff (rst)
        $fell(rej_n) |-> $past(start)); // R6
    AST_REJ_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (start && len > CNT_W'(1)) |=> ##1 !rej_n); // R9
endmodule

// File: rtl/sfd_byte_framer.sv
module sfd_byte_framer
    import sfdf_pkg::*;
#(
    parameter int NUM_ENT     = 4,
    parameter int ADDR_BYTES  = 6,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_active,
    input  logic                      rx_bclk,
    input  logic                      rx_data,
    input  logic [NUM_ENT*ADDR_W-1:0] tbl_addr,
    input  logic [NUM_ENT-1:0]        tbl_en,
    input  logic [CNT_W-1:0]          rej_len,
    output logic                      sof_mark,
    output logic [BYTE_W-1:0]         byte_out,
    output logic                      byte_vld,
    output logic                      rej_n
);
    logic     act;
    logic     bit_evt;
    logic     bit_val;
    rx_byte_t rx_byte;
    logic     miss;

    sfdf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .act_in(rx_active), .bclk_in(rx_bclk),
        .data_in(rx_data), .act(act), .bit_evt(bit_evt), .bit_val(bit_val)
    );

    sfdf_hunt u_hunt (
        .clk(clk), .rst(rst), .act(act), .bit_evt(bit_evt),
        .bit_val(bit_val), .mark(sof_mark), .rx_byte(rx_byte)
    );

    sfdf_addr_match #(.NUM_ENT(NUM_ENT), .ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk(clk), .rst(rst), .act(act), .rx_byte(rx_byte),
        .tbl_addr(tbl_addr), .tbl_en(tbl_en), .miss(miss)
    );

    sfdf_reject #(.CNT_W(CNT_W)) u_rej (
        .clk(clk), .rst(rst), .start(miss), .len(rej_len), .rej_n(rej_n)
    );

    assign byte_out = rx_byte.data;
    assign byte_vld = rx_byte.vld;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> rej_n && !byte_vld && !sof_mark); // R1
endmodule

// File: tb/sfd_byte_framer_test.sv
module sfd_byte_framer_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_active = 1'b0;
    logic         rx_bclk = 1'b0;
    logic         rx_data = 1'b0;
    logic [191:0] tbl_addr;
    logic [3:0]   tbl_en;
    logic [7:0]   rej_len;
    logic         sof_mark;
    logic [7:0]   byte_out;
    logic         byte_vld;
    logic         rej_n;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] E0 = 48'h6655_4433_2211;
    localparam logic [47:0] E1 = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] E2 = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] E3 = 48'h1234_5678_9ABC;

    // {expect_reject, destination address}
    localparam logic [48:0] VEC [6] = '{
        {1'b0, E0},
        {1'b0, E2},
        {1'b1, 48'h0A0B_0C0D_0E0E},
        {1'b1, 48'h0000_0000_0001},
        {1'b1, E3},
        {1'b0, E1}
    };

    sfd_byte_framer uut (
        .clk(clk), .rst(rst), .rx_active(rx_active), .rx_bclk(rx_bclk),
        .rx_data(rx_data), .tbl_addr(tbl_addr), .tbl_en(tbl_en),
        .rej_len(rej_len), .sof_mark(sof_mark), .byte_out(byte_out),
        .byte_vld(byte_vld), .rej_n(rej_n)
    );

    always #4 clk = ~clk;

    // monitor
    int         n_marks = 0;
    int         n_bytes = 0;
    int         n_rej = 0;
    int         cur_w = 0;
    int         last_w = 0;
    logic       prev_rej = 1'b1;
    logic [7:0] cap [16];

    always @(negedge clk) begin
        if (!rst) begin
            if (sof_mark) n_marks++;
            if (byte_vld) begin
                if (n_bytes < 16) cap[n_bytes] = byte_out;
                n_bytes++;
            end
            if (prev_rej && !rej_n) n_rej++;
            if (!rej_n) cur_w++;
            else if (cur_w != 0) begin
                last_w = cur_w;
                cur_w = 0;
            end
            prev_rej = rej_n;
        end
    end

    task automatic clear_mon();
        n_marks = 0; n_bytes = 0; n_rej = 0; last_w = 0;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        rx_data = b;
        rx_bclk = 1'b0;
        repeat (3) @(negedge clk);
        rx_bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_frame();
        rx_active = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_frame();
        rx_active = 1'b0;
        rx_bclk = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic send_preamble_sfd();
        for (int i = 0; i < 28; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
        end
        for (int i = 0; i < 3; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
        end
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    function automatic logic [7:0] frame_byte(logic [47:0] a, int k);
        return (k < 6) ? a[8*k +: 8] : 8'(8'hA5 + k);
    endfunction

    task automatic send_bytes(logic [47:0] a, int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = frame_byte(a, k);
            for (int j = 0; j < 8; j++) send_bit(v[j]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tbl_addr = {E3, E2, E1, E0};
        tbl_en   = 4'b0111;
        rej_len  = 8'd26;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rej_n", int'(rej_n), 1);
        check("R1 sof_mark", int'(sof_mark), 0);
        check("R1 byte_vld", int'(byte_vld), 0);

        // table-driven frames: R2 R4 R5 R6 R7 R8 (each frame re-arms after the last)
        for (int v = 0; v < 6; v++) begin
            logic [47:0] a;
            int er;
            a  = VEC[v][47:0];
            er = int'(VEC[v][48]);
            clear_mon();
            start_frame();
            send_preamble_sfd();
            send_bytes(a, 8);
            end_frame();
            check("R2 R4 marks", n_marks, 9);
            check("R4 byte count", n_bytes, 8);
            for (int k = 0; k < 8; k++)
                check("R4 R5 byte value", int'(cap[k]), int'(frame_byte(a, k)));
            check("R6 R7 reject count", n_rej, er);
            if (er == 1) check("R6 reject width", last_w, 26);
        end

        // R3 broken delimiter
        clear_mon();
        start_frame();
        for (int i = 0; i < 28; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
        end
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        for (int i = 0; i < 64; i++) send_bit(1'b0);
        end_frame();
        check("R3 broken pattern marks", n_marks, 0);
        check("R3 broken pattern bytes", n_bytes, 0);

        // R3 ones too soon after active
        clear_mon();
        start_frame();
        send_bit(1'b1); send_bit(1'b1);
        for (int i = 0; i < 40; i++) send_bit(1'b0);
        end_frame();
        check("R3 early ones marks", n_marks, 0);

        // R8 short frame with a missing address: no reject
        clear_mon();
        start_frame();
        send_preamble_sfd();
        send_bytes(48'h0000_0000_0001, 3);
        end_frame();
        check("R8 short frame bytes", n_bytes, 3);
        check("R8 short frame reject", n_rej, 0);

        // R9 miss then frame ends at once
        clear_mon();
        start_frame();
        send_preamble_sfd();
        send_bytes(48'h0000_0000_0002, 6);
        end_frame();
        check("R9 reject count", n_rej, 1);
        check("R9 reject width", last_w, 26);

        // R6 zero length acts as one
        rej_len = 8'd0;
        clear_mon();
        start_frame();
        send_preamble_sfd();
        send_bytes(48'h0000_0000_0003, 6);
        end_frame();
        check("R6 zero length count", n_rej, 1);
        check("R6 zero length width", last_w, 1);

        // R7 disabling entry 0 turns its match into a miss
        rej_len = 8'd26;
        tbl_en  = 4'b0110;
        clear_mon();
        start_frame();
        send_preamble_sfd();
        send_bytes(E0, 6);
        end_frame();
        check("R7 disabled entry reject", n_rej, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule